// File: doc/BRIEF.md
# Field Memory Write-Port Address Controller

This block is the write side of a serial field memory. One write clock carries a 12-bit word per cycle. The word is made of an 8-bit luma lane and a 4-bit chroma lane. The words are stored in a small register array organised as lines (X address) of bits (Y address). During sequential writing the pointer advances by itself. It moves to the next line at the end of a line and wraps after the last line.

Two control inputs have two meanings each, selected by the write-reset input. When write-reset is low, `we_i` is the write enable and `ade_i` requests a single-cycle address-set cycle. That cycle captures start addresses from the X and Y address buses. When write-reset is high, the cycle is a single-cycle pointer reset. In it, `we_i` picks the Y reset target and `ade_i` together with `xinc_i` picks the X reset target. A registered test read port returns any stored word, so the contents can be compared with a model.

Top module: `fm_wr_port`

## Requirements
- R1: In a normal cycle (`wr_rst_i`=0, `ade_i`=0) with `we_i`=1 and `ie_i`=1, the word {`din_y_i`,`din_c_i`} (luma in bits 11:4, chroma in bits 3:0) is written at the current (X,Y) on the rising edge, and Y advances by one.
- R2: With `we_i`=1 and `ie_i`=0 in a normal cycle, no memory word changes, but the pointer still advances.
- R3: With `we_i`=0 in a normal cycle, neither the pointer nor the memory changes.
- R4: An address-set cycle (`wr_rst_i`=0, `ade_i`=1) captures `x_addr_i` and `y_addr_i` into the preset registers in one clock. It leaves the pointer and the memory unchanged.
- R5: In a reset cycle (`wr_rst_i`=1), Y becomes 0 when `we_i`=0 and becomes the Y preset when `we_i`=1.
- R6: In a reset cycle, X becomes 0 when `ade_i`=0. When `ade_i`=1, X becomes the X preset if `xinc_i`=0, and X+1 (wrapping to 0 after NUM_LINES-1) if `xinc_i`=1.
- R7: No memory write occurs during a set or reset cycle, whatever the levels of `we_i` and `ie_i`.
- R8: When Y advances from LINE_LEN-1, it wraps to 0 and X advances by one. X wraps from NUM_LINES-1 to 0.
- R9: An address-set value outside the array (Y ≥ LINE_LEN or X ≥ NUM_LINES) is stored as 0 in that preset.
- R10: `rd_data_o` shows, one clock after the edge, the word held at (`rd_x_i`,`rd_y_i`) just before that edge. An out-of-range read address returns 0.
- R11: While `rst_ni` is low, the pointer, the presets, every memory word and `rd_data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write enable; Y reset select in reset cycles |
| ie_i | input | 1 | Data input mask (1 = store data) |
| wr_rst_i | input | 1 | Selects a reset cycle |
| ade_i | input | 1 | Address-set request; X reset select in reset cycles |
| xinc_i | input | 1 | Line step in reset cycles |
| x_addr_i | input | XW | Line address for set cycles |
| y_addr_i | input | YW | Bit-in-line address for set cycles |
| din_y_i | input | 8 | Luma data |
| din_c_i | input | 4 | Chroma data |
| wr_x_o | output | XW | Current write line address |
| wr_y_o | output | YW | Current write bit address |
| rd_x_i | input | XW | Test read line address |
| rd_y_i | input | YW | Test read bit address |
| rd_data_o | output | 12 | Registered test read word |

## Verification
The bench builds the block with LINE_LEN=6 and NUM_LINES=3. These are non-power-of-two sizes, so the address buses can carry values outside the array. That makes the preset clamping of R9 and the out-of-range reads of R10 reachable. Short lines also mean that Y and X wrap many times within a few thousand random cycles. Each cycle the read port samples a random cell, and at the end every cell is read back and compared with the model.

// File: rtl/fm_wr_pkg.sv
package fm_wr_pkg;
  localparam int Y_BITS = 8;
  localparam int C_BITS = 4;
  localparam int WORD_W = Y_BITS + C_BITS;

  typedef enum logic [1:0] {
    CYC_NORMAL = 2'd0,
    CYC_SET    = 2'd1,
    CYC_RESET  = 2'd2
  } fm_cyc_e;

  function automatic fm_cyc_e fm_decode(input logic wr_rst, input logic ade);
    if (wr_rst) return CYC_RESET;
    if (ade)    return CYC_SET;
    return CYC_NORMAL;
  endfunction
endpackage

// File: rtl/fm_wr_ptr.sv
module fm_wr_ptr
  import fm_wr_pkg::*;
#(
  parameter int LINE_LEN  = 16,
  parameter int NUM_LINES = 8,
  parameter int XW        = 3,
  parameter int YW        = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  fm_cyc_e       cyc_i,
  input  logic          we_i,
  input  logic          ade_i,
  input  logic          xinc_i,
  input  logic [XW-1:0] x_addr_i,
  input  logic [YW-1:0] y_addr_i,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o
);
  localparam logic [XW-1:0] X_LAST = XW'(NUM_LINES - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(LINE_LEN - 1);

  logic [XW-1:0] x_q, x_d, x_pre_q, x_step;
  logic [YW-1:0] y_q, y_d, y_pre_q;

  assign x_step = (x_q == X_LAST) ? '0 : x_q + 1'b1;

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    unique case (cyc_i)
      CYC_RESET: begin
        y_d = we_i ? y_pre_q : '0;
        if (!ade_i)      x_d = '0;
        else if (xinc_i) x_d = x_step;
        else             x_d = x_pre_q;
      end
      CYC_NORMAL: begin
        if (we_i) begin
          if (y_q == Y_LAST) begin
            y_d = '0;
            x_d = x_step;
          end else begin
            y_d = y_q + 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q     <= '0;
      y_q     <= '0;
      x_pre_q <= '0;
      y_pre_q <= '0;
    end else begin
      x_q <= x_d;
      y_q <= y_d;
      if (cyc_i == CYC_SET) begin
        x_pre_q <= (x_addr_i <= X_LAST) ? x_addr_i : '0;
        y_pre_q <= (y_addr_i <= Y_LAST) ? y_addr_i : '0;
      end
    end
  end

  assign x_o = x_q;
  assign y_o = y_q;

  AST_Y_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_q <= Y_LAST); // R8
  AST_X_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_q <= X_LAST); // R8
  AST_HOLD_WE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == CYC_NORMAL && !we_i) |=> ($stable(x_q) && $stable(y_q))); // R3
  AST_SET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == CYC_SET) |=> ($stable(x_q) && $stable(y_q))); // R4
  AST_RST_Y_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == CYC_RESET && !we_i) |=> (y_q == '0)); // R5
  AST_RST_Y_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == CYC_RESET && we_i) |=> (y_q == $past(y_pre_q))); // R5
  AST_RST_X_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == CYC_RESET && !ade_i) |=> (x_q == '0)); // R6
  AST_Y_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == CYC_NORMAL && we_i && y_q == Y_LAST) |=> (y_q == '0)); // R8
endmodule

// File: rtl/fm_wr_array.sv
module fm_wr_array
  import fm_wr_pkg::*;
#(
  parameter int LINE_LEN  = 16,
  parameter int NUM_LINES = 8,
  parameter int XW        = 3,
  parameter int YW        = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wen_i,
  input  logic [XW-1:0]     wx_i,
  input  logic [YW-1:0]     wy_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [XW-1:0]     rx_i,
  input  logic [YW-1:0]     ry_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = LINE_LEN * NUM_LINES;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] rdata_q;
  int unsigned       widx, ridx;
  logic              rd_ok;

  always_comb begin
    widx  = int'(wx_i) * LINE_LEN + int'(wy_i);
    ridx  = int'(rx_i) * LINE_LEN + int'(ry_i);
    rd_ok = (int'(rx_i) < NUM_LINES) && (int'(ry_i) < LINE_LEN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (wen_i && widx < DEPTH) mem_q[widx] <= wdata_i;
      rdata_q <= rd_ok ? mem_q[ridx] : '0;
    end
  end

  assign rdata_o = rdata_q;

  AST_WR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_i |-> (widx < DEPTH)); // R1
endmodule

// File: rtl/fm_wr_port.sv
module fm_wr_port
  import fm_wr_pkg::*;
#(
  parameter int LINE_LEN  = 16,
  parameter int NUM_LINES = 8,
  localparam int XW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int YW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1
) (
  input  logic              wclk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              ie_i,
  input  logic              wr_rst_i,
  input  logic              ade_i,
  input  logic              xinc_i,
  input  logic [XW-1:0]     x_addr_i,
  input  logic [YW-1:0]     y_addr_i,
  input  logic [Y_BITS-1:0] din_y_i,
  input  logic [C_BITS-1:0] din_c_i,
  output logic [XW-1:0]     wr_x_o,
  output logic [YW-1:0]     wr_y_o,
  input  logic [XW-1:0]     rd_x_i,
  input  logic [YW-1:0]     rd_y_i,
  output logic [WORD_W-1:0] rd_data_o
);
  fm_cyc_e       cyc;
  logic          wen;
  logic [XW-1:0] x_cur;
  logic [YW-1:0] y_cur;

  assign cyc = fm_decode(wr_rst_i, ade_i);
  assign wen = (cyc == CYC_NORMAL) && we_i && ie_i;

  fm_wr_ptr #(.LINE_LEN(LINE_LEN), .NUM_LINES(NUM_LINES), .XW(XW), .YW(YW)) u_ptr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .cyc_i(cyc), .we_i(we_i), .ade_i(ade_i),
    .xinc_i(xinc_i), .x_addr_i(x_addr_i), .y_addr_i(y_addr_i),
    .x_o(x_cur), .y_o(y_cur)
  );

  fm_wr_array #(.LINE_LEN(LINE_LEN), .NUM_LINES(NUM_LINES), .XW(XW), .YW(YW)) u_arr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .wen_i(wen), .wx_i(x_cur), .wy_i(y_cur),
    .wdata_i({din_y_i, din_c_i}), .rx_i(rd_x_i), .ry_i(rd_y_i), .rdata_o(rd_data_o)
  );

  assign wr_x_o = x_cur;
  assign wr_y_o = y_cur;

  AST_NO_WR_CTRL: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_rst_i || ade_i) |-> !wen); // R7
endmodule

// File: tb/fm_wr_port_tb.sv
module fm_wr_port_tb;
  localparam int LL = 6;
  localparam int NL = 3;
  localparam int XW = 2;
  localparam int YW = 3;

  logic wclk = 1'b0, rst_ni = 1'b0;
  logic we = 0, ie = 0, wrst = 0, ade = 0, xinc = 0;
  logic [XW-1:0] xa = '0, rx = '0, wr_x;
  logic [YW-1:0] ya = '0, ry = '0, wr_y;
  logic [7:0] dy = '0;
  logic [3:0] dc = '0;
  logic [11:0] rd;

  int checks = 0, fails = 0;
  int mx = 0, my = 0, px = 0, py = 0;
  logic [11:0] mem [NL][LL];

  always #10 wclk = ~wclk;

  fm_wr_port #(.LINE_LEN(LL), .NUM_LINES(NL)) u_dut (
    .wclk_i(wclk), .rst_ni(rst_ni), .we_i(we), .ie_i(ie), .wr_rst_i(wrst),
    .ade_i(ade), .xinc_i(xinc), .x_addr_i(xa), .y_addr_i(ya), .din_y_i(dy),
    .din_c_i(dc), .wr_x_o(wr_x), .wr_y_o(wr_y), .rd_x_i(rx), .rd_y_i(ry),
    .rd_data_o(rd)
  );

  function automatic int nxt_x(input int x);
    return (x == NL - 1) ? 0 : x + 1;
  endfunction

  function automatic logic [11:0] model_rd(input int x, input int y);
    if (x >= NL || y >= LL) return '0;
    return mem[x][y];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    if (wrst) begin
      my = we ? py : 0;
      if (!ade)      mx = 0;
      else if (xinc) mx = nxt_x(mx);
      else           mx = px;
    end else if (ade) begin
      px = (int'(xa) < NL) ? int'(xa) : 0;
      py = (int'(ya) < LL) ? int'(ya) : 0;
    end else if (we) begin
      if (ie) mem[mx][my] = {dy, dc};
      if (my == LL - 1) begin my = 0; mx = nxt_x(mx); end
      else my++;
    end
  endtask

  // Called at a falling edge; drives, clocks, and checks at the next falling edge.
  task automatic step(input logic i_we, input logic i_ie, input logic i_wrst,
                      input logic i_ade, input logic i_xinc, input int i_xa,
                      input int i_ya, input string tag);
    logic [11:0] exp_rd;
    we = i_we; ie = i_ie; wrst = i_wrst; ade = i_ade; xinc = i_xinc;
    xa = XW'(i_xa); ya = YW'(i_ya);
    dy = 8'($urandom); dc = 4'($urandom);
    rx = XW'($urandom); ry = YW'($urandom);
    exp_rd = model_rd(int'(rx), int'(ry));
    @(posedge wclk);
    model_edge();
    @(negedge wclk);
    chk({tag, " x pointer"}, int'(wr_x), mx);
    chk({tag, " y pointer"}, int'(wr_y), my);
    chk("R10 read port", int'(rd), int'(exp_rd));
  endtask

  initial begin
    repeat (100000) @(posedge wclk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int x = 0; x < NL; x++) for (int y = 0; y < LL; y++) mem[x][y] = '0;
    repeat (2) @(negedge wclk);
    chk("R11 reset x", int'(wr_x), 0);
    chk("R11 reset y", int'(wr_y), 0);
    chk("R11 reset rd", int'(rd), 0);
    rst_ni = 1'b1;
    @(negedge wclk);

    step(0, 1, 0, 1, 0, 1, 4, "R4 set");
    step(1, 1, 0, 0, 0, 0, 0, "R1 write");
    step(1, 1, 0, 0, 0, 0, 0, "R1 write");
    step(1, 1, 1, 1, 0, 0, 0, "R5 R6 R7 reset to preset");
    step(1, 0, 0, 0, 0, 0, 0, "R2 masked");
    step(1, 1, 0, 0, 0, 0, 0, "R8 line wrap");
    for (int i = 0; i < LL; i++) step(1, 1, 0, 0, 0, 0, 0, "R8 field wrap");
    step(0, 0, 0, 0, 0, 0, 0, "R3 hold");
    step(0, 1, 0, 0, 0, 0, 0, "R3 hold");
    step(0, 0, 0, 1, 0, 3, 7, "R9 clamp");
    step(1, 1, 1, 1, 0, 0, 0, "R9 R5 preset zero");
    step(1, 1, 1, 1, 1, 0, 0, "R6 xinc");
    step(1, 1, 1, 1, 1, 0, 0, "R6 xinc");
    step(1, 1, 1, 1, 1, 0, 0, "R6 xinc wrap");
    step(0, 1, 0, 1, 0, 2, 5, "R4 set");
    step(0, 1, 1, 0, 1, 0, 0, "R5 R6 zero");
    step(1, 1, 1, 1, 0, 0, 0, "R6 preset");

    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom % 10);
      if (r == 0)
        step(1'($urandom), 1'($urandom), 0, 1, 1'($urandom),
             int'($urandom % 4), int'($urandom % 8), "R4 R9 random set");
      else if (r == 1)
        step(1'($urandom), 1'($urandom), 1, 1'($urandom), 1'($urandom),
             0, 0, "R5 R6 R7 random reset");
      else
        step(($urandom % 5) != 0, ($urandom % 5) != 0, 0, 0, 1'($urandom),
             0, 0, "R1 R2 R3 R8 random write");
    end

    we = 0; ie = 0; wrst = 0; ade = 0;
    for (int x = 0; x < 4; x++) begin
      for (int y = 0; y < 8; y++) begin
        rx = XW'(x); ry = YW'(y);
        @(negedge wclk);
        chk("R10 final readback", int'(rd), int'(model_rd(x, y)));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule